// File: doc/BRIEF.md
# Escalating Multi-Stage Watchdog Timer

This block holds one watchdog per processor core. Each watchdog counts down a programmed period. Every period that ends without a service strobe pushes it one step up a ladder of escalation. The first unserviced period raises a maskable interrupt. The second raises a non-maskable interrupt. The third requests a soft reset of the whole chip. Software keeps a core alive by pulsing that core's poke input, or by rewriting its configuration word. Either action restarts the period and drops the core back to the bottom of the ladder.

The period comes from a 16-bit length value. That value forms the upper part of a down counter whose lower `PRESC_W` bits start at zero. The counter steps down once per prescaler tick, and a tick comes every 2^`PRESC_W` clocks. A 2-bit mode field sets how far up the ladder a core may climb, or stops the core altogether. A single status port returns, for a selected core, its interrupt, NMI and reset flags together with the live counter value. Handler code reads it to tell a watchdog NMI apart from other NMI sources.

Top module: `ewdt_top`

## Requirements
- R1: After a synchronous reset, every core is in mode 0 with length 0, all irq_o, nmi_o and srst_o bits are 0, and the status word reads 0 for every core.
- R2: A configuration write loads the selected core's counter with {length, PRESC_W zero bits}. The counter then drops by one every 2^PRESC_W clocks. With length L, each period lasts (L*2^PRESC_W + 1)*2^PRESC_W clocks, and the counter reloads at the end of every period.
- R3: When the first period after a load ends, irq_o of that core rises and stays high until the next load.
- R4: When the second consecutive unserviced period ends, nmi_o rises. nmi_o is only ever high together with irq_o.
- R5: In mode 3, the end of the third unserviced period raises srst_o. srst_o rises only after nmi_o has been high.
- R6: Mode 1 climbs no further than the interrupt, and mode 2 no further than the NMI. Further expiries leave the outputs unchanged.
- R7: Mode 0 holds the prescaler and the counter still and keeps irq_o and nmi_o low. A poke in mode 0 only reloads the counter.
- R8: A poke reloads the counter from the stored length and clears irq_o and nmi_o from the next cycle on. srst_o, once high, stays high until reset.
- R9: A configuration write to a core clears its irq_o and nmi_o and restarts its period, exactly as a poke does.
- R10: With length 0, the first expiry comes 2^PRESC_W clocks after the load, and not one clock sooner.
- R11: A poke or configuration write to one core leaves every other core's outputs and counter untouched.
- R12: Status word layout: bit 0 is irq_o, bit 1 is nmi_o (NMI stage reached), bit 2 is srst_o, and bits above bit 2 hold the counter value of the core chosen by rd_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Core addressed by the write |
| cfg_wdata | input | 18 | Bits 17:16 are the mode; bits 15:0 are the length |
| poke | input | NUM_CORES | One service strobe per core |
| irq_o | output | NUM_CORES | Interrupt level per core |
| nmi_o | output | NUM_CORES | Non-maskable interrupt level per core |
| srst_o | output | NUM_CORES | Sticky soft-reset request per core |
| rd_sel | input | SEL_W | Core shown on the status port |
| rd_data | output | 16+PRESC_W+3 | Status word of the selected core |

## Verification
Directed sequences run a single core through each mode. Each mode is tried with a few lengths, including length 0. These sequences show whether the period arithmetic, the ladder limits and the stickiness of the reset request are correct. A poke and a rewrite are then applied at the NMI and reset stages, which separates what a service clears from what only reset clears. Pokes to one core while its neighbours are mid-period show whether state leaks between instances. Several thousand cycles of seeded random writes, pokes and status selections then compare every output and the status word on every cycle against a closed-form model. That model derives the stage and the counter from the number of cycles since the last load.

// File: rtl/ewdt_pkg.sv
package ewdt_pkg;

    localparam int LEN_W  = 16;
    localparam int MODE_W = 2;
    localparam int CFG_W  = MODE_W + LEN_W;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_NMI  = 2'd2,
        MODE_FULL = 2'd3
    } wd_mode_e;

    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_IRQ  = 2'd1,
        STG_NMI  = 2'd2,
        STG_RST  = 2'd3
    } wd_stage_e;

    typedef struct packed {
        wd_mode_e           mode;
        logic [LEN_W-1:0]   len;
    } wd_cfg_t;

    // One rung up the ladder, capped at the highest rung the mode allows.
    function automatic wd_stage_e stage_step(input wd_stage_e cur, input wd_mode_e lim);
        logic [1:0] c;
        logic [1:0] l;
        c = cur;
        l = lim;
        if (c < l) begin
            return wd_stage_e'(c + 2'd1);
        end
        return cur;
    endfunction

    function automatic logic stage_at_nmi(input wd_stage_e s);
        return (s == STG_NMI) || (s == STG_RST);
    endfunction

endpackage

// File: rtl/ewdt_prescaler.sv
module ewdt_prescaler #(
    parameter int PW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick_o
);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run && (&div_q);

endmodule

// File: rtl/ewdt_downcnt.sv
module ewdt_downcnt
    import ewdt_pkg::*;
#(
    parameter  int PW    = 8,
    localparam int CNT_W = LEN_W + PW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             tick,
    output logic             expire_o,
    output logic [CNT_W-1:0] value_o
);

    logic [CNT_W-1:0] val_q;
    logic [CNT_W-1:0] reload_val;
    logic             at_zero;

    assign reload_val = {load_len, {PW{1'b0}}};
    assign at_zero    = (val_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (load || (tick && at_zero)) begin
            val_q <= reload_val;
        end else if (tick) begin
            val_q <= val_q - 1'b1;
        end
    end

    assign expire_o = tick && at_zero;
    assign value_o  = val_q;

endmodule

// File: rtl/ewdt_stage.sv
module ewdt_stage
    import ewdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      expire,
    input  wd_mode_e  mode,
    output wd_stage_e stage_o,
    output logic      srst_o
);

    wd_stage_e stage_q;
    wd_stage_e stage_nxt;
    logic      srst_q;

    assign stage_nxt = stage_step(stage_q, mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_IDLE;
            srst_q  <= 1'b0;
        end else if (clear) begin
            stage_q <= STG_IDLE;
        end else if (expire) begin
            stage_q <= stage_nxt;
            if (stage_nxt == STG_RST) begin
                srst_q <= 1'b1;
            end
        end
    end

    assign stage_o = stage_q;
    assign srst_o  = srst_q;

endmodule

// File: rtl/ewdt_core.sv
module ewdt_core
    import ewdt_pkg::*;
#(
    parameter  int PW     = 8,
    localparam int CNT_W  = LEN_W + PW,
    localparam int STAT_W = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wd_cfg_t           wdata,
    input  logic              poke,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              srst_o,
    output logic [STAT_W-1:0] stat_o
);

    wd_cfg_t          cfg_q;
    logic             load;
    logic             run;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] len_sel;
    logic [CNT_W-1:0] cnt_val;
    wd_stage_e        stage;
    logic             srst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_OFF, len: '0};
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    // a write restarts the period exactly like a poke, using the new length
    assign load    = we || poke;
    assign run     = (cfg_q.mode != MODE_OFF);
    assign len_sel = we ? wdata.len : cfg_q.len;

    ewdt_prescaler #(.PW(PW)) presc_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (load),
        .run    (run),
        .tick_o (tick)
    );

    ewdt_downcnt #(.PW(PW)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_len (len_sel),
        .tick     (tick),
        .expire_o (expire),
        .value_o  (cnt_val)
    );

    ewdt_stage stage_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .expire  (expire),
        .mode    (cfg_q.mode),
        .stage_o (stage),
        .srst_o  (srst)
    );

    assign irq_o  = (stage != STG_IDLE);
    assign nmi_o  = stage_at_nmi(stage);
    assign srst_o = srst;
    assign stat_o = {cnt_val, srst, stage_at_nmi(stage), (stage != STG_IDLE)};

endmodule

// File: rtl/ewdt_top.sv
module ewdt_top
    import ewdt_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    parameter  int PRESC_W   = 8,
    localparam int SEL_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W     = LEN_W + PRESC_W,
    localparam int STAT_W    = CNT_W + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [NUM_CORES-1:0] poke,
    output logic [NUM_CORES-1:0] irq_o,
    output logic [NUM_CORES-1:0] nmi_o,
    output logic [NUM_CORES-1:0] srst_o,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [STAT_W-1:0]    rd_data
);

    wd_cfg_t           wdata_s;
    logic [STAT_W-1:0] stat_w [NUM_CORES];

    assign wdata_s = wd_cfg_t'(cfg_wdata);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic core_we;
        assign core_we = cfg_we && (cfg_sel == SEL_W'(g));

        ewdt_core #(.PW(PRESC_W)) core_i (
            .clk    (clk),
            .rst    (rst),
            .we     (core_we),
            .wdata  (wdata_s),
            .poke   (poke[g]),
            .irq_o  (irq_o[g]),
            .nmi_o  (nmi_o[g]),
            .srst_o (srst_o[g]),
            .stat_o (stat_w[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (rd_sel == SEL_W'(c)) begin
                rd_data = stat_w[c];
            end
        end
    end

endmodule

// File: rtl/ewdt_chk.sv
module ewdt_chk #(
    parameter int NUM_CORES = 4,
    parameter int SEL_W     = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [SEL_W-1:0]     cfg_sel,
    input logic [NUM_CORES-1:0] poke,
    input logic [NUM_CORES-1:0] irq_o,
    input logic [NUM_CORES-1:0] nmi_o,
    input logic [NUM_CORES-1:0] srst_o
);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        // R8
        srst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            srst_o[g] |=> srst_o[g]);

        // R4
        nmi_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
            nmi_o[g] |-> irq_o[g]);

        // R5
        srst_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(srst_o[g]) |-> $past(nmi_o[g]));

        // R8
        poke_clears_chk: assert property (@(posedge clk) disable iff (rst)
            poke[g] |=> (!irq_o[g] && !nmi_o[g]));

        // R9
        write_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && (cfg_sel == SEL_W'(g))) |=> (!irq_o[g] && !nmi_o[g]));

        // R3
        irq_not_on_poke_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[g]) |-> !$past(poke[g]));
    end

endmodule

bind ewdt_top ewdt_chk #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .poke    (poke),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .srst_o  (srst_o)
);

// File: tb/ewdt_top_tb_top.sv
`timescale 1ns/1ps
module ewdt_top_tb_top;

    localparam int NC     = 3;
    localparam int PW     = 2;
    localparam int SEL_W  = 2;
    localparam int CNT_W  = 16 + PW;
    localparam int STAT_W = CNT_W + 3;
    localparam int TICK   = 1 << PW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [SEL_W-1:0]  cfg_sel = '0;
    logic [17:0]       cfg_wdata = '0;
    logic [NC-1:0]     poke = '0;
    logic [NC-1:0]     irq_o;
    logic [NC-1:0]     nmi_o;
    logic [NC-1:0]     srst_o;
    logic [SEL_W-1:0]  rd_sel = '0;
    logic [STAT_W-1:0] rd_data;

    int n_cmp  = 0;
    int n_fail = 0;

    int m_k    [NC];
    int m_len  [NC];
    int m_mode [NC];
    bit m_srst [NC];

    always #2 clk = ~clk;

    ewdt_top #(.NUM_CORES(NC), .PRESC_W(PW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .poke      (poke),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .srst_o    (srst_o),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    function automatic int period(input int l);
        return (l * TICK + 1) * TICK;
    endfunction

    function automatic int exp_stage(input int c);
        int s;
        s = m_k[c] / period(m_len[c]);
        if (s > m_mode[c]) s = m_mode[c];
        return s;
    endfunction

    function automatic int exp_cnt(input int c);
        int j;
        j = m_k[c] % period(m_len[c]);
        return m_len[c] * TICK - j / TICK;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic update_model();
        for (int c = 0; c < NC; c++) begin
            if (rst) begin
                m_k[c] = 0; m_len[c] = 0; m_mode[c] = 0; m_srst[c] = 1'b0;
            end else if (poke[c] || (cfg_we && cfg_sel == SEL_W'(c))) begin
                if (cfg_we && cfg_sel == SEL_W'(c)) begin
                    m_mode[c] = int'(cfg_wdata[17:16]);
                    m_len[c]  = int'(cfg_wdata[15:0]);
                end
                m_k[c] = 0;
            end else if (m_mode[c] != 0) begin
                m_k[c]++;
            end
            if (exp_stage(c) == 3) m_srst[c] = 1'b1;
        end
    endtask

    task automatic check_all();
        int s;
        int sel;
        for (int c = 0; c < NC; c++) begin
            s = exp_stage(c);
            check("R3 irq", 32'(irq_o[c]), 32'(s >= 1));
            check("R4 nmi", 32'(nmi_o[c]), 32'(s >= 2));
            check("R5 srst", 32'(srst_o[c]), 32'(m_srst[c]));
        end
        sel = int'(rd_sel);
        if (sel < NC) begin
            s = exp_stage(sel);
            // R12 flag positions, R2 counter field
            check("R12 flags", 32'(rd_data[2:0]), {29'd0, m_srst[sel], (s >= 2), (s >= 1)});
            check("R2 counter", 32'(rd_data[STAT_W-1:3]), 32'(exp_cnt(sel)));
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        update_model();
        check_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int core, input int mode, input int len);
        cfg_we    = 1'b1;
        cfg_sel   = SEL_W'(core);
        cfg_wdata = {2'(mode), 16'(len)};
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic do_poke(input int core);
        poke[core] = 1'b1;
        step();
        poke = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    initial begin
        logic [STAT_W-1:0] held;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) begin
            m_k[c] = 0; m_len[c] = 0; m_mode[c] = 0; m_srst[c] = 1'b0;
        end

        // R1: reset state
        run(3);
        rst = 1'b0;
        step();
        for (int c = 0; c < NC; c++) begin
            rd_sel = SEL_W'(c);
            step();
            check("R1 status", 32'(rd_data), 32'd0);
            check("R1 outputs", {29'd0, irq_o[c], nmi_o[c], srst_o[c]}, 32'd0);
        end

        // R2..R5: full ladder on core 0, length 2 (period 36)
        rd_sel = 2'd0;
        wr(0, 3, 2);
        check("R2 load value", 32'(rd_data[STAT_W-1:3]), 32'd8);
        run(35);
        check("R3 before first expiry", 32'(irq_o[0]), 32'd0);
        step();
        check("R3 first expiry", 32'(irq_o[0]), 32'd1);
        run(36);
        check("R4 second expiry", 32'(nmi_o[0]), 32'd1);
        run(36);
        check("R5 third expiry", 32'(srst_o[0]), 32'd1);

        // R8: poke clears irq/nmi but not the reset request
        do_poke(0);
        check("R8 irq cleared", 32'(irq_o[0]), 32'd0);
        check("R8 nmi cleared", 32'(nmi_o[0]), 32'd0);
        check("R8 srst held", 32'(srst_o[0]), 32'd1);
        check("R8 reload", 32'(rd_data[STAT_W-1:3]), 32'd8);
        run(40);

        // R6: mode caps
        rd_sel = 2'd1;
        wr(1, 1, 1);
        run(100);
        check("R6 mode1 irq", 32'(irq_o[1]), 32'd1);
        check("R6 mode1 no nmi", 32'(nmi_o[1]), 32'd0);
        wr(1, 2, 0);
        run(40);
        check("R6 mode2 nmi", 32'(nmi_o[1]), 32'd1);
        check("R6 mode2 no srst", 32'(srst_o[1]), 32'd0);

        // R7: disabled core holds still
        rd_sel = 2'd2;
        wr(2, 0, 5);
        held = rd_data;
        run(50);
        check("R7 counter held", 32'(rd_data), 32'(held));
        do_poke(2);
        run(20);
        check("R7 after poke", 32'(rd_data), 32'(held));
        check("R7 no irq", 32'(irq_o[2]), 32'd0);

        // R9: rewrite acts as service
        rd_sel = 2'd1;
        wr(1, 2, 3);
        check("R9 irq cleared", 32'(irq_o[1]), 32'd0);
        check("R9 nmi cleared", 32'(nmi_o[1]), 32'd0);
        check("R9 new length", 32'(rd_data[STAT_W-1:3]), 32'd12);

        // R10: zero length expires after one tick exactly
        wr(2, 3, 0);
        run(TICK - 1);
        check("R10 not yet", 32'(irq_o[2]), 32'd0);
        step();
        check("R10 one tick", 32'(irq_o[2]), 32'd1);

        // R11: pokes to core 0 leave core 1 escalating
        wr(0, 3, 1);
        wr(1, 3, 1);
        for (int i = 0; i < 6; i++) begin
            run(9);
            do_poke(0);
        end
        check("R11 core0 served", 32'(irq_o[0]), 32'd0);
        check("R11 core1 escalated", 32'(nmi_o[1]), 32'd1);

        // random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                cfg_we    = 1'b1;
                cfg_sel   = SEL_W'($urandom_range(0, NC - 1));
                cfg_wdata = {2'($urandom_range(0, 3)), 16'($urandom_range(0, 6))};
            end
            for (int c = 0; c < NC; c++) begin
                poke[c] = ($urandom_range(0, 59) == 0);
            end
            rd_sel = SEL_W'($urandom_range(0, NC - 1));
            step();
            cfg_we = 1'b0;
            poke   = '0;
        end

        // R8 / R1: only reset clears the reset request
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check("R8 srst cleared by reset", 32'(srst_o), 32'd0);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

endmodule